// File: doc/BRIEF.md
# DRAM Read-Return Latency Tracker

This controller-side block follows the command bus of an attached DDR4-style memory and predicts the clock cycle at which read data comes back. It keeps its own copy of the latency settings and the delay-locked-loop (DLL) state by decoding mode-register writes. For every READ it raises `rd_valid` for the four cycles that a burst of eight occupies, at two beats per cycle. With the DLL enabled, the window opens AL+CL cycles after the READ. With the DLL disabled, it opens one cycle earlier.

The block also tracks which banks are open and whether any burst is still expected. It uses this to report an all-idle status and to judge whether self-refresh entry is legal. Several protocol errors each produce a one-cycle pulse:

- a DLL change made outside initialization or self refresh;
- an unsupported latency pair while the DLL is off;
- self-refresh entry while busy;
- an unsanctioned NOP;
- a READ issued while a mode-register write is still settling.

Top module: `rd_return_tracker`

## Requirements
- R1: After reset the block reports the DLL on, CL=10, AL=0 and CWL=9. It also shows `rd_lat`=10, `all_idle`=1, `rd_valid`=0 and all error outputs at 0.
- R2: A command is decoded as follows. `cs_n`=0 with `act_n`=1 and `ras_n`/`cas_n`/`we_n` all 0 is a mode-register write, with the register number on `bank[2:0]`. In register 1, `addr[0]` is the DLL enable (1 on, 0 off) and `addr[4:3]` is the AL code. The tracked settings (`dll_on`, `rd_lat`) take the written value MOD_CYC cycles after the write.
- R3: With the DLL on, a READ (`cs_n`=0, `act_n`=1, `ras_n`=1, `cas_n`=0, `we_n`=1) sampled at edge 0 drives `rd_valid` high for cycles RL to RL+3, where RL=AL+CL. AL is 0, CL-1 or CL-2 for codes 0, 1 and 2.
- R4: With the DLL off, RL is AL+CL-1.
- R5: Reads in flight are tracked independently. Two READs sampled four cycles apart produce one unbroken 8-cycle window.
- R6: Writing a DLL enable value different from the current one raises `err_dll` for one cycle, unless `init_phase` is high or the device is in self refresh.
- R7: In register 0, `addr[5:0]` is CL. In register 2, `addr[5:0]` is CWL. Any mode-register write that leaves the DLL off with CL≠10 or CWL≠9 raises `err_lat`.
- R8: `all_idle` is high when no bank is open, no burst is pending and `cke` was high in the previous cycle.
  - ACT (`cs_n`=0, `act_n`=0) opens `bank`.
  - PRE (`act_n`=1, `ras_n`=0, `cas_n`=1, `we_n`=0) closes `bank`, or closes all banks when `addr[10]`=1.
  - A REF encoding (`ras_n`=0, `cas_n`=0, `we_n`=1) with `cke` low enters self refresh, which ends when `cke` returns high.
  - Entering self refresh while not idle raises `err_sre`.
- R9: A deselect (`cs_n`=1) issues nothing, whatever the other lines carry. Reads already in flight still produce their windows.
- R10: A NOP (`cs_n`=0 with `act_n`, `ras_n`, `cas_n`, `we_n` all 1) raises `err_nop` unless `nop_ok` is high.
- R11: A READ sampled within MOD_CYC cycles after a mode-register write raises `err_settle` and is timed with the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable seen by the device |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate line |
| ras_n | input | 1 | Row strobe line |
| cas_n | input | 1 | Column strobe line |
| we_n | input | 1 | Write enable line |
| bank | input | BA_W | Bank address, also selects the mode register |
| addr | input | ADDR_W | Address / mode-register payload |
| init_phase | input | 1 | High while the device is being initialized |
| nop_ok | input | 1 | High while a NOP is permitted |
| rd_valid | output | 1 | Read data expected this cycle |
| rd_lat | output | LAT_W+1 | Read latency currently in force |
| dll_on | output | 1 | Tracked DLL state |
| all_idle | output | 1 | All banks closed, no burst, clock enabled |
| err_dll | output | 1 | Illegal DLL change |
| err_lat | output | 1 | Unsupported latency with the DLL off |
| err_sre | output | 1 | Self-refresh entry while busy |
| err_nop | output | 1 | Unsanctioned NOP |
| err_settle | output | 1 | READ during mode-register settling |

## Verification
Some rules are checked on every cycle:

- a deselect never produces an error pulse;
- an unsanctioned NOP is always flagged, and the NOP flag has no other source;
- self-refresh entry while busy is always flagged;
- every read window lasts at least four cycles;
- any READ inside the settling window is flagged.

Only the bench scenarios can show the exact start cycle of each window under each DLL and AL combination, the merging of back-to-back windows, and the legality of DLL changes in and out of self refresh. They also show that a settling READ keeps the previous latency.

// File: rtl/rd_return_tracker.sv
module rd_return_tracker #(
  parameter int NUM_BANKS   = 16,
  parameter int BA_W        = $clog2(NUM_BANKS),
  parameter int ADDR_W      = 14,
  parameter int LAT_W       = 6,
  parameter int DEPTH       = 64,
  parameter int MOD_CYC     = 24,
  parameter int DLL_OFF_CL  = 10,
  parameter int DLL_OFF_CWL = 9,
  parameter int RST_CL      = 10,
  parameter int RST_CWL     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              init_phase,
  input  logic              nop_ok,
  output logic              rd_valid,
  output logic [LAT_W:0]    rd_lat,
  output logic              dll_on,
  output logic              all_idle,
  output logic              err_dll,
  output logic              err_lat,
  output logic              err_sre,
  output logic              err_nop,
  output logic              err_settle
);
  localparam int RLW = LAT_W + 1;
  localparam int CW  = $clog2(MOD_CYC + 1);
  localparam logic [DEPTH-1:0] WIN = DEPTH'(4'hF);

  wire sel   = !cs_n;
  wire c_act = sel & !act_n;
  wire c_mrs = sel & act_n & !ras_n & !cas_n & !we_n;
  wire c_ref = sel & act_n & !ras_n & !cas_n &  we_n;
  wire c_pre = sel & act_n & !ras_n &  cas_n & !we_n;
  wire c_rd  = sel & act_n &  ras_n & !cas_n &  we_n;
  wire c_nop = sel & act_n &  ras_n &  cas_n &  we_n;
  wire c_sre = c_ref & !cke;

  wire w0 = c_mrs & (bank[2:0] == 3'd0);
  wire w1 = c_mrs & (bank[2:0] == 3'd1);
  wire w2 = c_mrs & (bank[2:0] == 3'd2);

  logic             a_dll, p_dll;
  logic [LAT_W-1:0] a_cl, p_cl, p_cwl;
  logic [1:0]       a_al, p_al;
  logic [CW-1:0]    cnt;
  logic [NUM_BANKS-1:0] open_b;
  logic [DEPTH-1:0] sr;
  logic             cke_q, in_sr;

  wire             n_dll = w1 ? addr[0] : p_dll;
  wire [1:0]       n_al  = w1 ? addr[4:3] : p_al;
  wire [LAT_W-1:0] n_cl  = w0 ? addr[LAT_W-1:0] : p_cl;
  wire [LAT_W-1:0] n_cwl = w2 ? addr[LAT_W-1:0] : p_cwl;

  wire unused_ok = &{1'b0, addr[ADDR_W-1:11], addr[9:LAT_W], bank[BA_W-1:3]};

  logic [RLW-1:0] al_cyc;
  assign al_cyc = (a_al == 2'd1) ? RLW'(a_cl) - RLW'(1) :
                  (a_al == 2'd2) ? RLW'(a_cl) - RLW'(2) : '0;
  assign rd_lat   = RLW'(a_cl) + al_cyc - RLW'(!a_dll);
  assign dll_on   = a_dll;
  assign rd_valid = sr[0];
  assign all_idle = ~|open_b & ~|sr & cke_q;

  wire [NUM_BANKS-1:0] bhot = NUM_BANKS'(1) << bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_dll <= 1'b1; p_dll <= 1'b1;
      a_cl  <= LAT_W'(RST_CL); p_cl <= LAT_W'(RST_CL);
      p_cwl <= LAT_W'(RST_CWL);
      a_al  <= 2'd0; p_al <= 2'd0;
      cnt   <= '0;
      open_b <= '0;
      sr    <= '0;
      cke_q <= 1'b1;
      in_sr <= 1'b0;
      err_dll <= 1'b0; err_lat <= 1'b0; err_sre <= 1'b0;
      err_nop <= 1'b0; err_settle <= 1'b0;
    end else begin
      p_dll <= n_dll; p_al <= n_al; p_cl <= n_cl; p_cwl <= n_cwl;
      if (c_mrs) cnt <= CW'(MOD_CYC);
      else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          a_dll <= p_dll; a_cl <= p_cl; a_al <= p_al;
        end
      end

      if (c_act) open_b <= open_b | bhot;
      else if (c_pre) open_b <= addr[10] ? '0 : (open_b & ~bhot);

      sr <= (sr >> 1) | (c_rd ? (WIN << rd_lat) : '0);

      cke_q <= cke;
      if (c_sre) in_sr <= 1'b1;
      else if (in_sr && cke) in_sr <= 1'b0;

      err_dll    <= w1 & (addr[0] != p_dll) & !init_phase & !in_sr;
      err_lat    <= c_mrs & !n_dll & ((n_cl != LAT_W'(DLL_OFF_CL)) | (n_cwl != LAT_W'(DLL_OFF_CWL)));
      err_sre    <= c_sre & !all_idle;
      err_nop    <= c_nop & !nop_ok;
      err_settle <= c_rd & (cnt != '0);
    end
  end
endmodule

module rd_return_tracker_chk #(
  parameter int MOD_CYC = 24
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cs_n,
  input logic act_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic nop_ok,
  input logic rd_valid,
  input logic all_idle,
  input logic err_dll,
  input logic err_lat,
  input logic err_sre,
  input logic err_nop,
  input logic err_settle
);
  localparam int CW = $clog2(MOD_CYC + 1);
  logic [CW-1:0] since_mrs;
  wire is_mrs = !cs_n && act_n && !ras_n && !cas_n && !we_n;
  wire is_rd  = !cs_n && act_n && ras_n && !cas_n && we_n;
  wire is_nop = !cs_n && act_n && ras_n && cas_n && we_n;
  wire is_sre = !cs_n && act_n && !ras_n && !cas_n && we_n && !cke;

  always_ff @(posedge clk) begin
    if (!rst_n) since_mrs <= '0;
    else if (is_mrs) since_mrs <= CW'(MOD_CYC);
    else if (since_mrs != '0) since_mrs <= since_mrs - CW'(1);
  end

  AST_NOP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (is_nop && !nop_ok) |=> err_nop); // R10
  AST_NOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) err_nop |-> $past(is_nop)); // R10
  AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !(err_dll || err_lat || err_sre || err_nop || err_settle)); // R9
  AST_SRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (is_sre && !all_idle) |=> err_sre); // R8
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_valid) |-> $past(rd_valid, 4)); // R3
  AST_SETTLE_READ: assert property (@(posedge clk) disable iff (!rst_n) (is_rd && since_mrs != '0) |=> err_settle); // R11
endmodule

bind rd_return_tracker rd_return_tracker_chk #(.MOD_CYC(MOD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .act_n(act_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .nop_ok(nop_ok),
  .rd_valid(rd_valid), .all_idle(all_idle), .err_dll(err_dll),
  .err_lat(err_lat), .err_sre(err_sre), .err_nop(err_nop),
  .err_settle(err_settle)
);

// File: tb/rd_return_tracker_tb_top.sv
module rd_return_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MODC = 24;
  localparam int NV = 8;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {6'd10, 2'd0, 1'b1, 7'd10},
    {6'd12, 2'd1, 1'b1, 7'd23},
    {6'd14, 2'd2, 1'b1, 7'd26},
    {6'd10, 2'd0, 1'b0, 7'd9},
    {6'd10, 2'd1, 1'b0, 7'd18},
    {6'd10, 2'd2, 1'b0, 7'd17},
    {6'd16, 2'd0, 1'b1, 7'd16},
    {6'd10, 2'd0, 1'b1, 7'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [3:0] bank = '0;
  logic [13:0] addr = '0;
  logic init_phase = 1'b0, nop_ok = 1'b0;
  logic rd_valid, dll_on, all_idle, err_dll, err_lat, err_sre, err_nop, err_settle;
  logic [6:0] rd_lat;
  int n_chk = 0, n_bad = 0;

  rd_return_tracker #(.MOD_CYC(MODC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .act_n(act_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr),
    .init_phase(init_phase), .nop_ok(nop_ok), .rd_valid(rd_valid),
    .rd_lat(rd_lat), .dll_on(dll_on), .all_idle(all_idle),
    .err_dll(err_dll), .err_lat(err_lat), .err_sre(err_sre),
    .err_nop(err_nop), .err_settle(err_settle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive(input logic c, input logic a, input logic r, input logic s,
                       input logic w, input logic [3:0] b, input logic [13:0] d);
    cs_n = c; act_n = a; ras_n = r; cas_n = s; we_n = w; bank = b; addr = d;
  endtask

  task automatic desel(); drive(1, 1, 1, 1, 1, 4'd0, 14'd0); endtask
  task automatic desel_junk(); drive(1, 0, 0, 0, 0, 4'd3, 14'h3FF); endtask

  task automatic issue(input logic a, input logic r, input logic s, input logic w,
                       input logic [3:0] b, input logic [13:0] d);
    drive(0, a, r, s, w, b, d);
    @(negedge clk);
    desel();
  endtask

  task automatic mrs(input logic [3:0] mr, input logic [13:0] v); issue(1, 0, 0, 0, mr, v); endtask
  function automatic logic [13:0] mr1v(input logic [1:0] al, input logic dl);
    return {9'd0, al, 2'b00, dl};
  endfunction

  task automatic rd_window(input int rl, input string req, input bit junk, output logic st);
    drive(0, 1, 1, 0, 1, 4'd0, 14'd0);
    st = 1'b0;
    for (int i = 1; i <= rl + 5; i++) begin
      @(negedge clk);
      if (i == 1) begin
        st = err_settle;
        if (junk) desel_junk(); else desel();
      end
      if (i >= rl) check(req, rd_valid, (i >= rl + 1 && i <= rl + 4) ? 1 : 0);
    end
    desel();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic st;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dll", dll_on, 1);
    check("R1 lat", rd_lat, 10);
    check("R1 idle", all_idle, 1);
    check("R1 valid", rd_valid, 0);
    check("R1 errs", {err_dll, err_lat, err_sre, err_nop, err_settle}, 0);

    init_phase = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [5:0] cl; logic [1:0] al; logic dl; int rl;
      cl = VEC[k][15:10]; al = VEC[k][9:8]; dl = VEC[k][7]; rl = int'(VEC[k][6:0]);
      if (dl) begin mrs(4'd1, mr1v(al, dl)); mrs(4'd0, 14'(cl)); end
      else begin mrs(4'd0, 14'(cl)); mrs(4'd1, mr1v(al, dl)); end
      repeat (MODC) @(negedge clk);
      check("R2 dll", dll_on, dl);
      check(dl ? "R3 lat" : "R4 lat", rd_lat, rl);
      rd_window(rl, dl ? "R3 window" : "R4 window", 0, st);
      check("R11 none", st, 0);
    end
    init_phase = 1'b0;

    drive(0, 1, 1, 0, 1, 4'd0, 14'd0);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 4) drive(0, 1, 1, 0, 1, 4'd0, 14'd0); else desel();
      if (i >= 10) check("R5 merged", rd_valid, (i >= 11 && i <= 18) ? 1 : 0);
    end

    rd_window(10, "R9 window", 1, st);
    check("R9 idle", all_idle, 1);
    check("R9 errs", {err_dll, err_lat, err_sre, err_nop, err_settle}, 0);

    issue(1, 1, 1, 1, 4'd0, 14'd0);
    check("R10 nop bad", err_nop, 1);
    nop_ok = 1'b1;
    issue(1, 1, 1, 1, 4'd0, 14'd0);
    check("R10 nop ok", err_nop, 0);
    nop_ok = 1'b0;

    issue(0, 1, 1, 1, 4'd3, 14'd0);
    check("R8 busy", all_idle, 0);
    cke = 1'b0;
    issue(1, 0, 0, 1, 4'd0, 14'd0);
    check("R8 sre busy", err_sre, 1);
    cke = 1'b1;
    repeat (2) @(negedge clk);
    issue(1, 0, 1, 0, 4'd3, 14'd0);
    check("R8 closed", all_idle, 1);
    issue(0, 1, 1, 1, 4'd2, 14'd0);
    issue(0, 1, 1, 1, 4'd5, 14'd0);
    issue(1, 0, 1, 0, 4'd0, 14'h400);
    check("R8 pre all", all_idle, 1);
    cke = 1'b0;
    issue(1, 0, 0, 1, 4'd0, 14'd0);
    check("R8 sre idle", err_sre, 0);
    mrs(4'd1, mr1v(2'd0, 1'b0));
    check("R6 in sr", err_dll, 0);
    check("R7 ok", err_lat, 0);
    cke = 1'b1;
    repeat (2) @(negedge clk);
    repeat (MODC) @(negedge clk);
    check("R2 off", dll_on, 0);
    check("R4 lat", rd_lat, 9);
    mrs(4'd1, mr1v(2'd0, 1'b1));
    check("R6 illegal", err_dll, 1);
    repeat (MODC) @(negedge clk);
    check("R2 on", dll_on, 1);

    init_phase = 1'b1;
    mrs(4'd1, mr1v(2'd0, 1'b0));
    check("R6 init", err_dll, 0);
    check("R7 off ok", err_lat, 0);
    mrs(4'd0, 14'd11);
    check("R7 bad cl", err_lat, 1);
    mrs(4'd0, 14'd10);
    check("R7 cl ok", err_lat, 0);
    mrs(4'd2, 14'd10);
    check("R7 bad cwl", err_lat, 1);
    mrs(4'd2, 14'd9);
    check("R7 cwl ok", err_lat, 0);
    mrs(4'd1, mr1v(2'd0, 1'b1));
    init_phase = 1'b0;
    repeat (MODC) @(negedge clk);
    check("R2 on again", dll_on, 1);

    mrs(4'd0, 14'd12);
    @(negedge clk);
    rd_window(10, "R11 old", 0, st);
    check("R11 flag", st, 1);
    repeat (MODC) @(negedge clk);
    check("R11 new lat", rd_lat, 12);
    rd_window(12, "R11 new", 0, st);
    check("R11 clear", st, 0);

    summary();
  end
endmodule